// File: doc/BRIEF.md
# Six-State External Memory Bus Sequencer

This block produces the external bus waveforms of a small 8-bit controller. Time is counted in oscillator clocks. Twelve clocks make one machine cycle: six states, each split into two phases. Every output comes from a 0..11 phase count and a three-state controller, so each strobe edge falls on a fixed phase number.

A request asks for one of three operations. An instruction fetch takes one machine cycle. A data read or a data write takes two machine cycles: the instruction fetch comes first, then a transfer cycle. In the transfer cycle the code strobe stays quiet and the data read or data write strobe moves the byte instead. The low address byte and the data share one 8-bit port, which is driven or released under an output-enable. The high address byte has its own port. Bytes read from the bus come back on a single capture register, together with a one-clock pulse that tells whether the byte is code or data.

Controller states: `ST_IDLE` (no access), `ST_CODE` (instruction-fetch machine cycle) and `ST_XFER` (data-transfer machine cycle). Transitions:
- IDLE to CODE when a request arrives.
- CODE to XFER at phase 11 when the latched operation is a data access.
- CODE to CODE, or XFER to CODE, at phase 11 when a new request is accepted.
- CODE to IDLE, or XFER to IDLE, at phase 11 when no request waits.

Top module: `mbus_seq`

## Requirements
- R1: After reset: `addr_latch` and `lo_oe` are low, `hi_out` is 0, all three active-low strobes are high, and `req_ready` is high.
- R2: A machine cycle lasts exactly 12 clocks, numbered phase 0 to 11. `req_ready` is high only in idle or in phase 11 of an operation's final machine cycle.
- R3: In a fetch cycle, `addr_latch` is high in phases 0, 1, 6 and 7 and low in every other phase. `lo_oe` is high exactly while `addr_latch` is high, and `lo_out` then carries the low byte of the address of the current half-cycle.
- R4: In a fetch cycle, `code_rd_n` is low in phases 2 to 5. It is also low in phases 8 to 11 only when `req_two_byte` was 1.
- R5: In a fetch cycle, the address is `req_pc` in phases 0 to 5 and `req_pc`+1 (carrying into the high byte) in phases 6 to 11. `hi_out` shows the high byte of that address for the whole half-cycle.
- R6: `lo_in` is sampled on the clock that ends phase 5, and on the clock that ends phase 11 for a second byte. `rx_byte` then shows the byte with a one-clock `rx_code` pulse.
- R7: The `req_op` encoding is 0 = fetch, 1 = data read, 2 = data write; code 3 behaves as a fetch. A data op runs a fetch cycle and then a transfer cycle. In the transfer cycle `code_rd_n` stays high, and `addr_latch` is high only in phases 0 and 1, with the low byte of `req_daddr` on `lo_out`.
- R8: In a read transfer, `data_rd_n` is low in phases 2 to 9 and `lo_oe` is low in phases 2 to 11. `lo_in` is sampled on the clock that ends phase 9 and appears on `rx_byte` with a one-clock `rx_data` pulse.
- R9: In a write transfer, `data_wr_n` is low in phases 2 to 9. `lo_out` carries `req_wdata` with `lo_oe` high in phases 2 to 10, and the port is released in phase 11.
- R10: Throughout the transfer cycle, `hi_out` holds the high byte of `req_daddr`.
- R11: A request offered while `req_ready` is high is accepted and starts with phase 0 on the next clock, with no idle clock between operations. While `req_ready` is low, `req_valid` and the request fields have no effect.
- R12: At most one of `addr_latch`, `code_rd_n` low, `data_rd_n` low and `data_wr_n` low holds in any clock, and `lo_oe` is never high while a read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | Operation code (see R7) |
| req_two_byte | input | 1 | Fetch a second code byte |
| req_pc | input | 16 | Code address |
| req_daddr | input | 16 | Data address for read or write |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request accepted on this clock if valid |
| addr_latch | output | 1 | Address latch enable, active high |
| code_rd_n | output | 1 | Program-store read strobe, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Shared low port, value driven |
| lo_oe | output | 1 | Shared low port output enable |
| lo_in | input | 8 | Shared low port, value received |
| hi_out | output | 8 | High address byte port |
| rx_byte | output | 8 | Last captured byte |
| rx_code | output | 1 | One-clock pulse: `rx_byte` is a code byte |
| rx_data | output | 1 | One-clock pulse: `rx_byte` is a read data byte |

## Verification
In phase 11 of an operation's last cycle, two things can happen on one clock: a second code byte is captured, and a new request is accepted. The bench provokes this by chaining a two-byte fetch directly into a data read. It offers the read in phase 11 and drives the code byte on `lo_in` in the same phase. It then checks that `rx_code` and the correct `pc+1` byte appear on the very clock on which the next cycle shows phase 0 with `addr_latch` high and the new address. A second case offers a conflicting request in mid-cycle while `req_ready` is low, and checks that every strobe and address still follows the first request.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CODE = 2'd1,
        ST_XFER = 2'd2
    } mst_e;

    localparam logic [1:0] OP_FETCH = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;

    localparam int PH_PER_CYC   = 12;
    // fetch half-cycle: latch in first two phases, strobe in last four
    localparam int PH_HALF      = 6;
    localparam int PH_LATCH_END = 1;
    localparam int PH_CODE_BEG  = 2;
    localparam int PH_CODE_END  = 5;
    // transfer cycle
    localparam int PH_DSTB_BEG  = 2;
    localparam int PH_DSTB_END  = 9;
    localparam int PH_WHOLD_END = 10;

endpackage

// File: rtl/mbus_phase_ctr.sv
module mbus_phase_ctr #(
    parameter int PHASES = 12,
    parameter int PW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [PW-1:0] phase,
    output logic          last
);

    assign last = (phase == PW'(PHASES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (run) begin
            phase <= last ? '0 : phase + 1'b1;
        end
    end

    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && last) |=> (phase == '0));

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen
    import mbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int PW = 4
) (
    input  mst_e             state,
    input  logic [PW-1:0]    phase,
    input  logic [1:0]       op,
    input  logic             two_byte,
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    daddr,
    input  logic [DW-1:0]    wdata,
    output logic             addr_latch,
    output logic             code_rd_n,
    output logic             data_rd_n,
    output logic             data_wr_n,
    output logic [DW-1:0]    lo_out,
    output logic             lo_oe,
    output logic [AW-DW-1:0] hi_out
);

    logic [AW-1:0] pc_next;
    logic [AW-1:0] fetch_addr;
    logic [PW-1:0] half_ph;
    logic          second_half;

    function automatic logic in_rng(input logic [PW-1:0] p, input int lo, input int hi);
        return (p >= PW'(lo)) && (p <= PW'(hi));
    endfunction

    assign pc_next     = pc + 1'b1;
    assign second_half = (phase >= PW'(PH_HALF));
    assign half_ph     = second_half ? phase - PW'(PH_HALF) : phase;
    assign fetch_addr  = second_half ? pc_next : pc;

    always_comb begin
        addr_latch = 1'b0;
        code_rd_n  = 1'b1;
        data_rd_n  = 1'b1;
        data_wr_n  = 1'b1;
        lo_out     = '0;
        lo_oe      = 1'b0;
        hi_out     = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_CODE: begin
                addr_latch = in_rng(half_ph, 0, PH_LATCH_END);
                code_rd_n  = !(in_rng(half_ph, PH_CODE_BEG, PH_CODE_END)
                               && (!second_half || two_byte));
                lo_oe      = addr_latch;
                lo_out     = fetch_addr[DW-1:0];
                hi_out     = fetch_addr[AW-1:DW];
            end
            ST_XFER: begin
                addr_latch = in_rng(phase, 0, PH_LATCH_END);
                data_rd_n  = !((op == OP_READ)  && in_rng(phase, PH_DSTB_BEG, PH_DSTB_END));
                data_wr_n  = !((op == OP_WRITE) && in_rng(phase, PH_DSTB_BEG, PH_DSTB_END));
                lo_oe      = addr_latch
                             || ((op == OP_WRITE) && in_rng(phase, PH_DSTB_BEG, PH_WHOLD_END));
                lo_out     = addr_latch ? daddr[DW-1:0] : wdata;
                hi_out     = daddr[AW-1:DW];
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_two_byte,
    input  logic [AW-1:0]    req_pc,
    input  logic [AW-1:0]    req_daddr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic             addr_latch,
    output logic             code_rd_n,
    output logic             data_rd_n,
    output logic             data_wr_n,
    output logic [DW-1:0]    lo_out,
    output logic             lo_oe,
    input  logic [DW-1:0]    lo_in,
    output logic [AW-DW-1:0] hi_out,
    output logic [DW-1:0]    rx_byte,
    output logic             rx_code,
    output logic             rx_data
);

    localparam int PW = $clog2(PH_PER_CYC);

    mst_e          state, state_nx;
    logic [PW-1:0] phase;
    logic          last;
    logic          accept;
    logic          op_is_data;
    logic [1:0]    op_q;
    logic          two_q;
    logic [AW-1:0] pc_q, daddr_q;
    logic [DW-1:0] wdata_q;

    assign op_is_data = (op_q == OP_READ) || (op_q == OP_WRITE);
    assign req_ready  = (state == ST_IDLE)
                        || (last && ((state == ST_XFER) || ((state == ST_CODE) && !op_is_data)));
    assign accept     = req_valid && req_ready;

    mbus_phase_ctr #(.PHASES(PH_PER_CYC), .PW(PW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .phase (phase),
        .last  (last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_CODE;
            ST_CODE: if (last) begin
                if (op_is_data)     state_nx = ST_XFER;
                else if (req_valid) state_nx = ST_CODE;
                else                state_nx = ST_IDLE;
            end
            ST_XFER: if (last) state_nx = req_valid ? ST_CODE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_FETCH;
            two_q   <= 1'b0;
            pc_q    <= '0;
            daddr_q <= '0;
            wdata_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_q    <= req_op;
                two_q   <= req_two_byte;
                pc_q    <= req_pc;
                daddr_q <= req_daddr;
                wdata_q <= req_wdata;
            end
        end
    end

    mbus_strobe_gen #(.AW(AW), .DW(DW), .PW(PW)) u_stb (
        .state      (state),
        .phase      (phase),
        .op         (op_q),
        .two_byte   (two_q),
        .pc         (pc_q),
        .daddr      (daddr_q),
        .wdata      (wdata_q),
        .addr_latch (addr_latch),
        .code_rd_n  (code_rd_n),
        .data_rd_n  (data_rd_n),
        .data_wr_n  (data_wr_n),
        .lo_out     (lo_out),
        .lo_oe      (lo_oe),
        .hi_out     (hi_out)
    );

    // capture on the clock that ends the last strobe phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rx_code <= 1'b0;
            rx_data <= 1'b0;
        end else begin
            rx_code <= 1'b0;
            rx_data <= 1'b0;
            if ((state == ST_CODE) && ((phase == PW'(PH_CODE_END))
                || (two_q && phase == PW'(PH_HALF + PH_CODE_END)))) begin
                rx_byte <= lo_in;
                rx_code <= 1'b1;
            end
            if ((state == ST_XFER) && (op_q == OP_READ) && (phase == PW'(PH_DSTB_END))) begin
                rx_byte <= lo_in;
                rx_data <= 1'b1;
            end
        end
    end

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({addr_latch, !code_rd_n, !data_rd_n, !data_wr_n}) <= 1);

    assert_no_contend_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_rd_n || !data_rd_n) |-> !lo_oe);

    assert_code_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_code |-> (code_rd_n && !$past(code_rd_n)));

    assert_read_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data |-> (data_rd_n && !$past(data_rd_n)));

    assert_xfer_no_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |-> code_rd_n);

    assert_hi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && phase != '0) |-> $stable(hi_out));

    assert_ready_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !last) |-> !req_ready);

endmodule

// File: tb/sim_mbus_seq.sv
`timescale 1ns/1ps
module sim_mbus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_two_byte = 1'b0;
    logic [15:0] req_pc = '0;
    logic [15:0] req_daddr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  lo_in = 8'hEE;
    logic        req_ready, addr_latch, code_rd_n, data_rd_n, data_wr_n, lo_oe;
    logic        rx_code, rx_data;
    logic [7:0]  lo_out, hi_out, rx_byte;

    int vecs = 0;
    int errs = 0;
    int ticks = 0;

    always #5 clk = ~clk;

    mbus_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_two_byte(req_two_byte), .req_pc(req_pc), .req_daddr(req_daddr),
        .req_wdata(req_wdata), .req_ready(req_ready), .addr_latch(addr_latch),
        .code_rd_n(code_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
        .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out),
        .rx_byte(rx_byte), .rx_code(rx_code), .rx_data(rx_data)
    );

    function automatic logic [7:0] code_of(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] dmem(input logic [15:0] a);
        return ~a[7:0] + a[15:8];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected {addr_latch, code_rd_n, data_rd_n, data_wr_n, lo_oe, hi_out, masked lo_out}
    function automatic logic [20:0] exp_vec(input logic [1:0] op, input logic [15:0] pc,
        input bit two, input logic [15:0] da, input logic [7:0] wd, input int t, input int n);
        int p = t % 12;
        logic al = 1'b0, crd = 1'b1, drd = 1'b1, dwr = 1'b1, oe = 1'b0;
        logic [15:0] a = '0;
        logic [7:0]  lo = '0;
        if (t >= n) begin
        end else if (t < 12) begin
            al  = (p == 0) || (p == 1) || (p == 6) || (p == 7);
            crd = !((p >= 2 && p <= 5) || (two && p >= 8));
            oe  = al;
            a   = (p < 6) ? pc : pc + 16'd1;
            lo  = a[7:0];
        end else begin
            al  = (p < 2);
            drd = !(op == 2'd1 && p >= 2 && p <= 9);
            dwr = !(op == 2'd2 && p >= 2 && p <= 9);
            oe  = (p < 2) || (op == 2'd2 && p <= 10);
            a   = da;
            lo  = (p < 2) ? da[7:0] : wd;
        end
        return {al, crd, drd, dwr, oe, a[15:8], oe ? lo : 8'h00};
    endfunction

    function automatic logic [7:0] bus_in(input logic [1:0] op, input logic [15:0] pc,
        input bit two, input logic [15:0] da, input int t, input int n);
        int p = t % 12;
        if (t >= n) return 8'hEE;
        if (t < 12) begin
            if (p >= 2 && p <= 5) return code_of(pc);
            if (p >= 8) return code_of(pc + 16'd1);
            return 8'hEE;
        end
        if (op == 2'd1 && p >= 2 && p <= 9) return dmem(da);
        return 8'hEE;
    endfunction

    task automatic do_acc(input logic [1:0] op, input logic [15:0] pc, input bit two,
        input logic [15:0] da, input logic [7:0] wd, input bit started, input bit poke,
        input bit chain, input logic [1:0] nop, input logic [15:0] npc, input bit ntwo,
        input logic [15:0] nda, input logic [7:0] nwd);
        int n = (op == 2'd1 || op == 2'd2) ? 24 : 12;
        logic [20:0] act, exp;
        string tg;
        if (!started) begin
            @(negedge clk);
            req_valid = 1'b1; req_op = op; req_pc = pc; req_two_byte = two;
            req_daddr = da; req_wdata = wd;
            chk(req_ready == 1'b1, "R11 ready to accept", 32'(req_ready), 32'd1);
            @(negedge clk);
        end
        req_valid = 1'b0;
        for (int t = 0; t <= n; t++) begin
            lo_in = bus_in(op, pc, two, da, t, n);
            if (!(started && t == 0)) begin
                chk(rx_code == ((t == 6) || (t == 12 && two)), "R6 rx_code pulse",
                    32'(rx_code), 32'((t == 6) || (t == 12 && two)));
                chk(rx_data == (op == 2'd1 && t == 22), "R8 rx_data pulse",
                    32'(rx_data), 32'(op == 2'd1 && t == 22));
                if (t == 6) chk(rx_byte == code_of(pc), "R6 first code byte", 32'(rx_byte), 32'(code_of(pc)));
                if (t == 12 && two) chk(rx_byte == code_of(pc + 16'd1), "R6 second code byte",
                    32'(rx_byte), 32'(code_of(pc + 16'd1)));
                if (t == 22 && op == 2'd1) chk(rx_byte == dmem(da), "R8 read data byte",
                    32'(rx_byte), 32'(dmem(da)));
            end
            if (t == n && chain) return;
            exp = exp_vec(op, pc, two, da, wd, t, n);
            act = {addr_latch, code_rd_n, data_rd_n, data_wr_n, lo_oe, hi_out, lo_oe ? lo_out : 8'h00};
            tg = (t >= n) ? "R1 R2 idle after op" : (t < 12) ? "R3 R4 R5 fetch cycle" : "R7 R8 R9 R10 transfer cycle";
            chk(act == exp, tg, 32'(act), 32'(exp));
            chk(req_ready == (t >= n - 1), "R2 R11 ready window", 32'(req_ready), 32'(t >= n - 1));
            chk(($countones({addr_latch, !code_rd_n, !data_rd_n, !data_wr_n}) <= 1)
                && !(lo_oe && (!code_rd_n || !data_rd_n)), "R12 exclusive strobes", 32'(act), 32'(exp));
            if (poke && t == 3) begin
                req_valid = 1'b1; req_op = 2'd2; req_pc = 16'hFFFF; req_two_byte = 1'b1;
                req_daddr = 16'h0000; req_wdata = 8'h00;
            end
            if (poke && t == 4) req_valid = 1'b0;
            if (chain && t == n - 1) begin
                req_valid = 1'b1; req_op = nop; req_pc = npc; req_two_byte = ntwo;
                req_daddr = nda; req_wdata = nwd;
            end
            if (t < n) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({addr_latch, code_rd_n, data_rd_n, data_wr_n, lo_oe, hi_out} == {5'b01110, 8'h00},
            "R1 outputs in reset", 32'({addr_latch, code_rd_n, data_rd_n, data_wr_n, lo_oe, hi_out}),
            32'({5'b01110, 8'h00}));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(rx_code == 1'b0 && rx_data == 1'b0, "R1 no capture pulse", 32'({rx_code, rx_data}), 32'd0);
    endtask

    task automatic t_fetch_one();   do_acc(2'd0, 16'h1234, 1'b0, 16'h0, 8'h0, 0, 0, 0, 2'd0, 16'h0, 0, 16'h0, 8'h0); endtask
    task automatic t_fetch_carry(); do_acc(2'd0, 16'h12FF, 1'b1, 16'h0, 8'h0, 0, 0, 0, 2'd0, 16'h0, 0, 16'h0, 8'h0); endtask
    task automatic t_read();        do_acc(2'd1, 16'h0040, 1'b0, 16'hA55A, 8'h0, 0, 0, 0, 2'd0, 16'h0, 0, 16'h0, 8'h0); endtask
    task automatic t_write_poke();  do_acc(2'd2, 16'h2000, 1'b1, 16'h7F01, 8'hC3, 0, 1, 0, 2'd0, 16'h0, 0, 16'h0, 8'h0); endtask
    task automatic t_op3_fetch();   do_acc(2'd3, 16'h8001, 1'b1, 16'h5555, 8'h11, 0, 0, 0, 2'd0, 16'h0, 0, 16'h0, 8'h0); endtask
    task automatic t_chain();
        // R11: two-byte fetch chained straight into a read, capture and accept on one clock
        do_acc(2'd0, 16'h0100, 1'b1, 16'h0, 8'h0, 0, 0, 1, 2'd1, 16'h0102, 1'b1, 16'h0203, 8'h0);
        do_acc(2'd1, 16'h0102, 1'b1, 16'h0203, 8'h0, 1, 0, 0, 2'd0, 16'h0, 0, 16'h0, 8'h0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    always @(posedge clk) begin
        ticks++;
        if (ticks > 20000) begin
            errs++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", ticks);
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fetch_one();
        t_fetch_carry();
        t_read();
        t_write_poke();
        t_op3_fetch();
        t_chain();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule